// File: doc/BRIEF.md
# LDPC Encoder Column Word Assembler

This block sits at the input of a quasi-cyclic LDPC encoder. It takes a bit stream 64 lanes wide, framed by start, end and valid, together with a base-graph select and a 16-bit lifting size Z. It packs the information bits of each base-graph column into one Z-bit word and presents that word with its column index and the frame's lifting size. The encoder core that consumes the words is not part of the block. Its processing time is modelled by a fixed interval after the last column, during which the ready flag stays low.

Frames with an illegal lifting size are dropped at their first beat. Frames that end on the wrong beat, or data beats that arrive without a preceding start, are discarded and flagged with a one-cycle error pulse. A new start always wins: it abandons whatever frame is being collected and begins a fresh one.

Top module: `ldpc_col_assembler`

## Requirements
- R1: After reset, ready is 1 and out_valid and err are 0.
- R2: A frame has 22 columns when the sampled graph select is 0 and 10 when it is 1. Words come out with out_col counting 0,1,2,… in order, and out_last is 1 only on the final column.
- R3: Each column takes ceil(Z/64) valid beats. On beat b of a column, lane l carries column bit b*64+l. Lanes at or above Z on the final beat are ignored. out_word bit i equals column bit i for i < Z and is 0 for i >= Z.
- R4: Graph select and lifting size are sampled only on a beat where valid and start are both 1. They are held for the whole frame, and out_z repeats the sampled Z with every word. Beats with valid at 0 have no effect, whatever their start, end or data.
- R5: A lifting size is legal when it equals a·2^j, with a in {2,3,5,7,9,11,13,15}, j >= 0 and a result no larger than 384. A start beat with any other size (0 included) produces an err pulse on the next cycle, emits no word and leaves ready at 1.
- R6: A valid start beat while a frame is being collected abandons that frame without an error, and the new frame is assembled correctly from that beat on.
- R7: If end is 1 on a beat other than the last beat of the frame, or is 0 on that last beat, err pulses on the next cycle. The frame is then dropped: no further word is emitted, including the final column, and ready returns to 1.
- R8: A valid beat without start while no frame is being collected produces an err pulse and no word.
- R9: ready is 0 from the cycle after an accepted start until the frame finishes. The cycle in which the last word is presented is the first of BUSY_CYCLES cycles with ready at 0, and ready is 1 in the cycle after those.
- R10: A word is presented in the cycle that follows the clock edge on which its column's final beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | LANES | Input lanes, lane 0 first |
| in_start | input | 1 | First beat of frame |
| in_end | input | 1 | Last beat of frame |
| in_valid | input | 1 | Beat qualifier |
| in_bg | input | 1 | Base-graph select: 0 gives 22 columns, 1 gives 10 |
| in_z | input | 16 | Lifting size Z |
| out_word | output | ZMAX | Assembled column, bit i is column bit i |
| out_col | output | CW | Column index |
| out_valid | output | 1 | Word strobe |
| out_last | output | 1 | Final column of the frame |
| out_z | output | 16 | Lifting size of the frame |
| ready | output | 1 | A new frame may start |
| err | output | 1 | One-cycle pulse on a rejected beat or frame |

## Verification
The bench sends every legal lifting size under both graph selects. Single-beat columns, partial last beats and six-beat columns are all covered. Ignored lanes, idle beats and the Z and select inputs on non-start beats carry junk, so a design that leaks unused lanes into a word or re-samples Z part-way through a frame returns corrupted words. Every illegal size up to 400 is offered as a start, which catches a legality test that confuses the odd factor or the range. Early end, missing end, stray data and mid-frame restart are each driven on their own. A design that emits the final column anyway, raises an error on a restart, or mistimes the busy window gives a wrong column count, a wrong err value or a wrong ready value on a specific cycle.

// File: rtl/ldpc_col_assembler.sv
module ldpc_col_assembler #(
  parameter int LANES = 64,
  parameter int ZMAX = 384,
  parameter int BUSY_CYCLES = 16,
  parameter int NCOL0 = 22,
  parameter int NCOL1 = 10,
  localparam int CW = $clog2(NCOL0)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] in_data,
  input  logic             in_start,
  input  logic             in_end,
  input  logic             in_valid,
  input  logic             in_bg,
  input  logic [15:0]      in_z,
  output logic [ZMAX-1:0]  out_word,
  output logic [CW-1:0]    out_col,
  output logic             out_valid,
  output logic             out_last,
  output logic [15:0]      out_z,
  output logic             ready,
  output logic             err
);
  localparam int BPC = (ZMAX + LANES - 1) / LANES;
  localparam int BW = $clog2(BPC + 1);
  localparam int KW = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_BUSY} st_t;
  st_t st;

  logic            bg_q;
  logic [15:0]     z_q;
  logic [BW-1:0]   nb_q, beat_q;
  logic [CW-1:0]   col_q;
  logic [ZMAX-1:0] word_q;
  logic [KW-1:0]   busy_q;

  function automatic logic size_ok(input logic [15:0] z);
    logic [15:0] v;
    v = z;
    for (int i = 0; i < 16; i++)
      if (v != '0 && !v[0]) v = v >> 1;
    return (z >= 16'd2) && (z <= 16'(ZMAX)) && (v < 16'd16);
  endfunction

  logic            z_ok, first, cbg, last_beat, last_col, take, end_bad, emit;
  logic [15:0]     cz, shamt;
  logic [16:0]     nb_calc;
  logic [BW-1:0]   cnb, cbeat;
  logic [CW-1:0]   ccol, ncol;
  logic [ZMAX-1:0] asm_w, zmask;

  assign z_ok      = size_ok(in_z);
  assign first     = in_valid && in_start;
  assign nb_calc   = ({1'b0, in_z} + 17'(LANES - 1)) / 17'(LANES);
  assign cz        = first ? in_z : z_q;
  assign cbg       = first ? in_bg : bg_q;
  assign cnb       = first ? BW'(nb_calc) : nb_q;
  assign cbeat     = first ? '0 : beat_q;
  assign ccol      = first ? '0 : col_q;
  assign ncol      = cbg ? CW'(NCOL1) : CW'(NCOL0);
  assign last_beat = (cbeat == cnb - BW'(1));
  assign last_col  = (ccol == ncol - CW'(1));
  assign take      = first ? z_ok : (in_valid && st == S_RUN);
  assign end_bad   = take && (in_end != (last_beat && last_col));
  assign emit      = take && !end_bad && last_beat;
  assign shamt     = 16'(cbeat) * 16'(LANES);
  assign asm_w     = ((cbeat == '0) ? '0 : word_q)
                   | ({{(ZMAX-LANES){1'b0}}, in_data} << shamt);
  assign zmask     = ~({ZMAX{1'b1}} << cz);
  assign ready     = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      bg_q <= 1'b0; z_q <= '0; nb_q <= '0; beat_q <= '0; col_q <= '0;
      word_q <= '0; busy_q <= '0;
      out_word <= '0; out_col <= '0; out_valid <= 1'b0; out_last <= 1'b0;
      out_z <= '0; err <= 1'b0;
    end else begin
      out_valid <= emit;
      err <= 1'b0;
      if (emit) begin
        out_word <= asm_w & zmask;
        out_col  <= ccol;
        out_last <= last_col;
        out_z    <= cz;
      end
      if (take) begin
        word_q <= asm_w;
        if (first) begin
          bg_q <= in_bg; z_q <= in_z; nb_q <= BW'(nb_calc);
        end
        if (last_beat) begin
          beat_q <= '0; col_q <= ccol + CW'(1);
        end else begin
          beat_q <= cbeat + BW'(1); col_q <= ccol;
        end
      end
      if (first && !z_ok) begin
        err <= 1'b1;
        st  <= S_IDLE;
      end else if (take) begin
        if (end_bad) begin
          err <= 1'b1;
          st  <= S_IDLE;
        end else if (last_beat && last_col) begin
          st <= S_BUSY;
          busy_q <= '0;
        end else begin
          st <= S_RUN;
        end
      end else begin
        if (in_valid) err <= 1'b1;
        if (st == S_BUSY) begin
          if (busy_q == KW'(BUSY_CYCLES - 1)) st <= S_IDLE;
          else busy_q <= busy_q + KW'(1);
        end
      end
    end
  end

  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_col < (bg_q ? CW'(NCOL1) : CW'(NCOL0)))); // R2
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_word & ({ZMAX{1'b1}} << out_z)) == '0)); // R3
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_z >= 16'd2 && out_z <= 16'(ZMAX))); // R5
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_start && !z_ok) |=> (err && !out_valid)); // R5
  AST_ERR_NO_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid); // R7
  AST_START_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_start && z_ok) |=> !ready); // R9
  AST_LAST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> !ready); // R9
endmodule

// File: tb/sim_ldpc_col_assembler.sv
`timescale 1ns/1ps
module sim_ldpc_col_assembler;
  localparam int ZMAX = 384;
  localparam int BUSY = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n = 1'b0;
  logic [63:0]     in_data = '0;
  logic            in_start = 1'b0, in_end = 1'b0, in_valid = 1'b0, in_bg = 1'b0;
  logic [15:0]     in_z = '0;
  logic [ZMAX-1:0] out_word;
  logic [4:0]      out_col;
  logic            out_valid, out_last, ready, err;
  logic [15:0]     out_z;

  ldpc_col_assembler #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_start(in_start),
    .in_end(in_end), .in_valid(in_valid), .in_bg(in_bg), .in_z(in_z),
    .out_word(out_word), .out_col(out_col), .out_valid(out_valid),
    .out_last(out_last), .out_z(out_z), .ready(ready), .err(err));

  int n_cmp = 0, n_bad = 0;
  int cur_f = 0, cur_z = 2, exp_col = 0, got_cols = 0, err_seen = 0;
  bit cur_bg = 1'b0, quiet = 1'b1, done = 1'b0;
  bit legal [0:400];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit gbit(input int f, input int k);
    logic [31:0] x;
    x = 32'(k) * 32'h9E3779B1 + 32'(f) * 32'h7F4A7C15;
    x = x ^ (x >> 15);
    return x[7];
  endfunction

  function automatic int nc(input bit bg);
    return bg ? 10 : 22;
  endfunction

  always @(posedge clk) begin
    #1;
    if (rst_n && err) err_seen++;
    if (rst_n && out_valid) begin
      if (quiet) chk(1'b0, "R5/R7/R8 no word expected", 1, 0);
      else begin
        logic [ZMAX-1:0] e;
        for (int i = 0; i < ZMAX; i++)
          e[i] = (i < cur_z) ? gbit(cur_f, exp_col * cur_z + i) : 1'b0;
        chk(out_word == e, "R3 word bits (count of wrong bits)", $countones(out_word ^ e), 0);
        chk(int'(out_col) == exp_col, "R2 column index", out_col, exp_col);
        chk(out_last == (exp_col == nc(cur_bg) - 1), "R2 last flag", out_last, exp_col == nc(cur_bg) - 1);
        chk(int'(out_z) == cur_z, "R4 lifting size out", out_z, cur_z);
        exp_col++;
        got_cols++;
      end
    end
  end

  task automatic drive(input logic [63:0] d, input bit s, input bit e, input bit v,
                       input bit b, input logic [15:0] z);
    @(negedge clk);
    in_data = d; in_start = s; in_end = e; in_valid = v; in_bg = b; in_z = z;
  endtask

  task automatic idle();
    drive(64'hA5A5_F00F_3C3C_1234, 1'b1, 1'b1, 1'b0, 1'b1, 16'hFFFF);
  endtask

  // mode 0: end on the real last beat, 1: end on the last beat sent, 2: never end
  task automatic send(input int f, input int z, input bit bg, input int limit, input int mode);
    int nb, total, n, c, b;
    logic [63:0] d;
    bit e;
    nb = (z + 63) / 64;
    total = nc(bg) * nb;
    n = (limit < total) ? limit : total;
    for (int t = 0; t < n; t++) begin
      c = t / nb;
      b = t % nb;
      for (int l = 0; l < 64; l++)
        d[l] = (b * 64 + l < z) ? gbit(f, c * z + b * 64 + l) : 1'b1;
      e = (mode == 0) ? (t == total - 1) : (mode == 1) ? (t == n - 1) : 1'b0;
      if (t > 0 && t % 5 == 0) drive(~d, 1'b1, 1'b1, 1'b0, !bg, 16'(z + 1));
      drive(d, t == 0, e, 1'b1, (t == 0) ? bg : !bg, (t == 0) ? 16'(z) : 16'(z ^ 16'h0155));
      if (t == 0) begin
        cur_f = f; cur_z = z; cur_bg = bg; exp_col = 0; got_cols = 0; quiet = 1'b0;
      end
    end
  endtask

  task automatic full_frame(input int f, input int z, input bit bg, input bit wait_rdy);
    int eb;
    bit low_ok;
    if (wait_rdy) while (!ready) idle();
    eb = err_seen;
    send(f, z, bg, 1 << 30, 0);
    idle();
    chk(got_cols == nc(bg), "R2 column count", got_cols, nc(bg));
    chk(out_valid && out_last, "R10 last word one cycle after final beat", out_valid, 1);
    low_ok = !ready;
    for (int k = 2; k <= BUSY; k++) begin
      idle();
      if (ready) low_ok = 1'b0;
    end
    chk(low_ok, "R9 ready low for the busy window", low_ok, 1);
    idle();
    chk(ready, "R9 ready returns after the busy window", ready, 1);
    chk(err_seen == eb, "R6/R4 well-formed frame raises no error", err_seen - eb, 0);
    quiet = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R9 watchdog expired: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int f, eb;
    f = 1;
    for (int i = 0; i <= 400; i++) legal[i] = 1'b0;
    foreach (legal[i]) begin end
    for (int a = 2; a <= 15; a++)
      if (a == 2 || a % 2 == 1)
        for (int v = a; v <= 384; v = v * 2) legal[v] = 1'b1;

    repeat (3) idle();
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(ready && !out_valid && !err, "R1 reset state", {ready, out_valid, err}, 3'b100);

    for (int z = 1; z <= 384; z++)
      if (legal[z])
        for (int bg = 0; bg < 2; bg++) begin
          full_frame(f, z, bg[0], 1'b1);
          f++;
        end

    for (int z = 0; z <= 400; z++)
      if (!legal[z]) begin
        quiet = 1'b1;
        drive(64'hFFFF_0000_FFFF_0000, 1'b1, 1'b0, 1'b1, z[0], 16'(z));
        idle();
        chk(err && ready && !out_valid, "R5 illegal size rejected", {err, ready, out_valid}, 3'b110);
      end

    quiet = 1'b1;
    drive(64'h1234_5678_9ABC_DEF0, 1'b0, 1'b0, 1'b1, 1'b0, 16'd64);
    idle();
    chk(err && !out_valid, "R8 stray beat flagged", {err, out_valid}, 2'b10);

    send(f, 104, 1'b1, 5, 1); f++;
    idle();
    chk(err, "R7 early end flagged", err, 1);
    chk(got_cols == 2, "R7 columns before early end", got_cols, 2);
    chk(ready, "R7 ready after early end", ready, 1);
    quiet = 1'b1;
    drive(64'h0F0F_0F0F_0F0F_0F0F, 1'b0, 1'b0, 1'b1, 1'b1, 16'd104);
    idle();
    chk(err, "R7 rest of dropped frame is stray", err, 1);

    send(f, 2, 1'b1, 1 << 30, 2); f++;
    idle();
    chk(err, "R7 missing end flagged", err, 1);
    chk(got_cols == 9, "R7 final column withheld", got_cols, 9);
    chk(ready, "R7 ready after missing end", ready, 1);
    quiet = 1'b1;
    repeat (3) idle();

    send(f, 64, 1'b1, 3, 2); f++;
    idle();
    chk(got_cols == 3, "R6 columns before restart", got_cols, 3);
    chk(!ready, "R9 ready low while collecting", ready, 0);
    eb = err_seen;
    full_frame(f, 24, 1'b0, 1'b0); f++;
    chk(err_seen == eb, "R6 restart raises no error", err_seen - eb, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule